// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup

This block holds the tag, valid and data storage of a two-way set-associative cache, together with the logic that looks up a request and picks the line to replace. A processor request carries an address, and may carry a write. Its address is cut into a tag, a set index and a word offset. The index reads one set. The stored tags of both ways are compared with the request tag at the same time. The two match signals are ORed into a single hit, and the same match signals steer the multiplexer that returns the word. The returned word therefore exists only after the hit decision and the way choice are made. The lookup result appears one cycle after the request.

Each set keeps one replacement bit. After every hit or refill, the bit names the way that was not just used. On a miss the block reports which way a refill would take. An empty way is taken first, otherwise the way named by the replacement bit. The next-level memory sits outside the block. It returns whole lines through a refill port, and the block chooses the target way itself. On a write hit only the addressed word of the matching way changes. A write miss leaves the cache untouched.

With the default parameters (32-bit address and data, 1024 sets, four words per line) the organisation is 32 KB with 16-byte lines. The address splits into an 18-bit tag in bits 31:14, a 10-bit set index in bits 13:4 and a word offset in bits 3:2.

Top module: `cache2w_lookup`

## Requirements
- R1: The word offset is taken from address bits [OFF+WORD_W-1:OFF], where OFF is log2 of the data bytes. The set index comes from the next SET_W bits and the tag from all remaining upper bits. The byte-within-word bits are ignored.
- R2: A request accepted in one cycle gives rsp_valid high in the next cycle only. While rsp_valid is low, rsp_hit and rsp_victim are 0.
- R3: rsp_hit is 1 when either way of the indexed set is valid and holds the request tag. On a hit, rsp_rdata is the addressed word of the matching way. On a miss, rsp_rdata is 0.
- R4: After reset every line is invalid, so every lookup misses.
- R5: A refill writes the whole line, its tag and its valid bit. It goes into an empty way first, and way 0 is preferred when both ways are empty.
- R6: On a miss, rsp_victim (0 = way 0, 1 = way 1) names the way a refill of that set would use: an empty way first, otherwise the way named by the set's replacement bit. When both ways are full, the refill replaces that way.
- R7: A lookup hit sets the set's replacement bit to the way that did not hit. A miss leaves the bit unchanged.
- R8: A refill sets the set's replacement bit to the way it did not fill.
- R9: A write hit replaces only the addressed word of the hitting way. The response to that write returns the old word. A write miss changes nothing and allocates nothing.
- R10: A refill whose tag is already present and valid in the set overwrites that way. At most one way ever matches a lookup.
- R11: When refill_valid is high in the same cycle as a hit response, the refill is applied, and that hit's word write and replacement-bit update are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Lookup result present (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_rdata | output | DATA_W | Hit word, zero on a miss |
| rsp_victim | output | 1 | Way a refill would take, on a miss |
| refill_valid | input | 1 | Line refill from next-level memory |
| refill_addr | input | ADDR_W | Address of the refilled line |
| refill_line | input | DATA_W*2^WORD_W | Line contents, word 0 in the low bits |

## Verification
The bench builds the block with SET_W = 3 and leaves the other parameters at their defaults: 8 sets, 4 words per line and a 25-bit tag. With only eight sets, addresses a few hundred bytes apart alias to the same set. That makes it easy to fill both ways, evict through the replacement bit, re-refill a tag already present, and make a high-bit tag difference miss. A second set then carries the refill/hit collision and the replacement-bit update after a refill, without disturbing the first.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef logic way_t;

  // Empty way first (way 0 preferred), otherwise the recorded victim.
  function automatic way_t pick_victim(input logic v0, input logic v1, input way_t lru);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru;
  endfunction

  function automatic way_t other_way(input way_t w);
    return ~w;
  endfunction

endpackage

// File: rtl/cache2w_match.sv
module cache2w_match #(
  parameter int TAG_W = 18
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] want_tag,
  output logic             match
);
  always_comb match = line_valid && (line_tag == want_tag);
endmodule

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SET_W  = 10,
  parameter int TAG_W  = 18,
  parameter int DATA_W = 32,
  parameter int WORD_W = 2,
  localparam int SETS   = 1 << SET_W,
  localparam int LINE_W = DATA_W << WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup read port
  input  logic [SET_W-1:0]  lk_set,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [LINE_W-1:0] lk_line,
  // refill probe port
  input  logic [SET_W-1:0]  pr_set,
  output logic              pr_valid,
  output logic [TAG_W-1:0]  pr_tag,
  // line fill
  input  logic              fill_en,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  // word write
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld_q <= '0;
    else if (fill_en) vld_q[fill_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[fill_set]  <= fill_tag;
      line_mem[fill_set] <= fill_line;
    end else if (wr_en) begin
      line_mem[wr_set][int'(wr_word)*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_comb begin
    lk_valid = vld_q[lk_set];
    lk_tag   = tag_mem[lk_set];
    lk_line  = line_mem[lk_set];
    pr_valid = vld_q[pr_set];
    pr_tag   = tag_mem[pr_set];
  end
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SET_W = 10,
  localparam int SETS = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             upd_val,
  output logic [SETS-1:0]  lru_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_vec <= '0;
    else if (upd_en) lru_vec[upd_set] <= upd_val;
  end
endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 10,
  parameter int WORD_W = 2,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W - OFF_W,
  localparam int SETS   = 1 << SET_W,
  localparam int LINE_W = DATA_W << WORD_W,
  localparam int NWAYS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_victim,
  input  logic              refill_valid,
  input  logic [ADDR_W-1:0] refill_addr,
  input  logic [LINE_W-1:0] refill_line
);
  import cache2w_pkg::*;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W+WORD_W +: SET_W];
  endfunction
  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: WORD_W];
  endfunction

  logic unused_byte_off;
  assign unused_byte_off = ^req_addr[OFF_W-1:0] ^ ^refill_addr[OFF_W+WORD_W-1:0];

  // request stage
  logic              stg_vld, stg_wr;
  logic [TAG_W-1:0]  stg_tag;
  logic [SET_W-1:0]  stg_set;
  logic [WORD_W-1:0] stg_word;
  logic [DATA_W-1:0] stg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld   <= 1'b0;
      stg_wr    <= 1'b0;
      stg_tag   <= '0;
      stg_set   <= '0;
      stg_word  <= '0;
      stg_wdata <= '0;
    end else begin
      stg_vld <= req_valid;
      if (req_valid) begin
        stg_wr    <= req_write;
        stg_tag   <= tag_of(req_addr);
        stg_set   <= set_of(req_addr);
        stg_word  <= word_of(req_addr);
        stg_wdata <= req_wdata;
      end
    end
  end

  // refill address fields
  logic [TAG_W-1:0] rf_tag;
  logic [SET_W-1:0] rf_set;
  always_comb begin
    rf_tag = tag_of(refill_addr);
    rf_set = set_of(refill_addr);
  end

  // per-way storage and comparators
  logic              lk_valid [NWAYS];
  logic [TAG_W-1:0]  lk_tag   [NWAYS];
  logic [LINE_W-1:0] lk_line  [NWAYS];
  logic              pr_valid [NWAYS];
  logic [TAG_W-1:0]  pr_tag   [NWAYS];
  logic [NWAYS-1:0]  way_match, rf_dup, fill_en, wr_en;

  logic             hit, hit_upd;
  way_t             hit_way, victim, rf_way;
  logic [SETS-1:0]  lru_vec;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    cache2w_way #(
      .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .WORD_W(WORD_W)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_set   (stg_set),
      .lk_valid (lk_valid[w]),
      .lk_tag   (lk_tag[w]),
      .lk_line  (lk_line[w]),
      .pr_set   (rf_set),
      .pr_valid (pr_valid[w]),
      .pr_tag   (pr_tag[w]),
      .fill_en  (fill_en[w]),
      .fill_set (rf_set),
      .fill_tag (rf_tag),
      .fill_line(refill_line),
      .wr_en    (wr_en[w]),
      .wr_set   (stg_set),
      .wr_word  (stg_word),
      .wr_data  (stg_wdata)
    );

    cache2w_match #(.TAG_W(TAG_W)) u_lk_cmp (
      .line_valid(lk_valid[w]), .line_tag(lk_tag[w]),
      .want_tag(stg_tag), .match(way_match[w])
    );

    cache2w_match #(.TAG_W(TAG_W)) u_rf_cmp (
      .line_valid(pr_valid[w]), .line_tag(pr_tag[w]),
      .want_tag(rf_tag), .match(rf_dup[w])
    );

    always_comb begin
      fill_en[w] = refill_valid && (rf_way == way_t'(w));
      wr_en[w]   = hit_upd && stg_wr && way_match[w];
    end
  end

  // hit combine, way select, victim choice
  always_comb begin
    hit     = |way_match;
    hit_way = way_match[1];
    hit_upd = stg_vld && hit && !refill_valid;
    victim  = pick_victim(lk_valid[0], lk_valid[1], lru_vec[stg_set]);
    if (rf_dup[0])      rf_way = 1'b0;
    else if (rf_dup[1]) rf_way = 1'b1;
    else                rf_way = pick_victim(pr_valid[0], pr_valid[1], lru_vec[rf_set]);
  end

  // replacement state
  logic             lru_upd_en, lru_upd_val;
  logic [SET_W-1:0] lru_upd_set;
  always_comb begin
    lru_upd_en  = refill_valid || hit_upd;
    lru_upd_set = refill_valid ? rf_set : stg_set;
    lru_upd_val = refill_valid ? other_way(rf_way) : other_way(hit_way);
  end

  cache2w_lru #(.SET_W(SET_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .upd_en(lru_upd_en), .upd_set(lru_upd_set), .upd_val(lru_upd_val),
    .lru_vec(lru_vec)
  );

  // response
  always_comb begin
    rsp_valid  = stg_vld;
    rsp_hit    = stg_vld && hit;
    rsp_rdata  = rsp_hit ? lk_line[hit_way][int'(stg_word)*DATA_W +: DATA_W] : '0;
    rsp_victim = (stg_vld && !hit) ? victim : 1'b0;
  end
endmodule

// File: rtl/cache2w_lookup_chk.sv
module cache2w_lookup_chk #(
  parameter int SET_W  = 10,
  parameter int DATA_W = 32,
  localparam int SETS  = 1 << SET_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_victim,
  input logic [1:0]        way_match,
  input logic              hit_upd,
  input logic [SET_W-1:0]  stg_set,
  input logic              hit_way,
  input logic [SETS-1:0]   lru_vec
);
  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_victim)); // R2
  AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_rdata == '0)); // R3
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(way_match) <= 1)); // R10
  AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_upd |=> (lru_vec[$past(stg_set)] != $past(hit_way))); // R7
endmodule

bind cache2w_lookup cache2w_lookup_chk #(.SET_W(SET_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
  .rsp_victim(rsp_victim), .way_match(way_match), .hit_upd(hit_upd),
  .stg_set(stg_set), .hit_way(hit_way), .lru_vec(lru_vec)
);

// File: tb/cache2w_lookup_test.sv
`timescale 1ns/1ps
module cache2w_lookup_test;
  localparam int AW = 32, DW = 32, SW = 3, WW = 2, LW = DW << WW;
  localparam logic [31:0] SALT = 32'h0F0F_0F0F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_hit, rsp_victim;
  logic [DW-1:0] rsp_rdata;
  logic refill_valid = 1'b0;
  logic [AW-1:0] refill_addr = '0;
  logic [LW-1:0] refill_line = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cache2w_lookup #(.ADDR_W(AW), .DATA_W(DW), .SET_W(SW), .WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .rsp_victim(rsp_victim),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_line(refill_line)
  );

  // memory model: word w of the line holding address a
  function automatic logic [31:0] mw(input logic [31:0] a, input int w);
    return {a[31:4], 4'h0} ^ (32'(w) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  typedef struct packed {
    logic [1:0]  op;   // 0 read, 1 write, 2 refill (wd = salt)
    logic [31:0] addr;
    logic [31:0] wd;
    logic        hit;
    logic [31:0] data;
    logic        vic;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 32'h14,  32'h0, 1'b0, 32'h0, 1'b0},             // R4 R6 cold miss
    '{2'd2, 32'h10,  32'h0, 1'b0, 32'h0, 1'b0},             // R5 fill way0
    '{2'd0, 32'h14,  32'h0, 1'b1, mw(32'h10, 1), 1'b0},     // R3
    '{2'd0, 32'h90,  32'h0, 1'b0, 32'h0, 1'b1},             // R6 empty way1
    '{2'd2, 32'h90,  32'h0, 1'b0, 32'h0, 1'b0},             // R5 fill way1
    '{2'd0, 32'h98,  32'h0, 1'b1, mw(32'h90, 2), 1'b0},     // R3
    '{2'd0, 32'h1C,  32'h0, 1'b1, mw(32'h10, 3), 1'b0},     // R7 lru->1
    '{2'd0, 32'h110, 32'h0, 1'b0, 32'h0, 1'b1},             // R6 R7 victim=lru
    '{2'd2, 32'h110, 32'h0, 1'b0, 32'h0, 1'b0},             // R6 evict way1
    '{2'd0, 32'h90,  32'h0, 1'b0, 32'h0, 1'b0},             // R6 R8 evicted
    '{2'd0, 32'h114, 32'h0, 1'b1, mw(32'h110, 1), 1'b0},    // R6
    '{2'd1, 32'h114, 32'hDEAD_BEEF, 1'b1, mw(32'h110, 1), 1'b0}, // R9 old word
    '{2'd0, 32'h114, 32'h0, 1'b1, 32'hDEAD_BEEF, 1'b0},     // R9
    '{2'd0, 32'h110, 32'h0, 1'b1, mw(32'h110, 0), 1'b0},    // R9 other word
    '{2'd1, 32'h90,  32'h1234_5678, 1'b0, 32'h0, 1'b0},     // R9 write miss
    '{2'd0, 32'h90,  32'h0, 1'b0, 32'h0, 1'b0},             // R9 no allocate
    '{2'd0, 32'h13,  32'h0, 1'b1, mw(32'h10, 0), 1'b0},     // R1 byte bits
    '{2'd2, 32'h10,  SALT,  1'b0, 32'h0, 1'b0},             // R10 same tag
    '{2'd0, 32'h18,  32'h0, 1'b1, mw(32'h10, 2) ^ SALT, 1'b0}, // R10
    '{2'd0, 32'h118, 32'h0, 1'b1, mw(32'h110, 2), 1'b0},    // R10 kept
    '{2'd0, 32'h04,  32'h0, 1'b0, 32'h0, 1'b0},             // R4 set0 cold
    '{2'd0, 32'h8000_0010, 32'h0, 1'b0, 32'h0, 1'b0}        // R1 high tag bit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic refill(input logic [31:0] a, input logic [31:0] salt);
    @(negedge clk);
    refill_valid = 1'b1;
    refill_addr  = a;
    for (int w = 0; w < 4; w++) refill_line[w*32 +: 32] = mw(a, w) ^ salt;
    @(negedge clk);
    refill_valid = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic eh, input logic [31:0] ed, input logic ev, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"}, 32'(rsp_hit), 32'(eh));
    chk({req, " rdata"}, rsp_rdata, ed);
    chk({req, " victim"}, 32'(rsp_victim), 32'(ev));
    @(negedge clk);
    chk("R2 rsp_valid drops", 32'(rsp_valid), 32'd0);
  endtask

  initial begin : watchdog
    for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R2 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R2 reset rsp_hit", 32'(rsp_hit), 32'd0);
    chk("R3 reset rdata", rsp_rdata, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].op == 2'd2) refill(TBL[i].addr, TBL[i].wd);
      else access(TBL[i].op == 2'd1, TBL[i].addr, TBL[i].wd,
                  TBL[i].hit, TBL[i].data, TBL[i].vic, $sformatf("R3 vec%0d", i));
    end

    // R11: write hit response coincides with a refill of set2
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h10; req_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R11 write hit seen", 32'(rsp_hit), 32'd1);
    refill_valid = 1'b1; refill_addr = 32'h20;
    for (int w = 0; w < 4; w++) refill_line[w*32 +: 32] = mw(32'h20, w);
    @(negedge clk);
    refill_valid = 1'b0;
    access(1'b0, 32'h8000_0010, 32'h0, 1'b0, 32'h0, 1'b0, "R11 lru not moved");
    access(1'b0, 32'h10, 32'h0, 1'b1, mw(32'h10, 0) ^ SALT, 1'b0, "R11 write dropped");
    access(1'b0, 32'h24, 32'h0, 1'b1, mw(32'h20, 1), 1'b0, "R11 refill applied");

    // R8: refill marks the filled way as recently used (set2)
    refill(32'hA0, 32'h0);
    access(1'b0, 32'h120, 32'h0, 1'b0, 32'h0, 1'b0, "R8 victim after fill way1");
    refill(32'h120, 32'h0);
    access(1'b0, 32'h20, 32'h0, 1'b0, 32'h0, 1'b1, "R8 victim after fill way0");
    access(1'b0, 32'hAC, 32'h0, 1'b1, mw(32'hA0, 3), 1'b0, "R8 way1 kept");
    access(1'b0, 32'h128, 32'h0, 1'b1, mw(32'h120, 2), 1'b0, "R5 replaced line");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule